// File: doc/BRIEF.md
# Two-Step Subranging Converter Decoder

This block is the digital back end of a two-step subranging analog-to-digital converter. A coarse estimator of six comparators reports a thermometer word. The block turns that word into a 2-bit window code. The window code steers a multiplexer that connects one shared bank of eight comparators to a group of eight taps on a 32-tap coarse ladder. The same eight comparators are then sampled twice. The first pass reads the coarse ladder. The block then switches the comparators to the fine ladder, and the second pass reads the residue.

The block combines the window code with the count of ones from each pass. It applies the overlap correction, limits the sum to the output range and presents an 8-bit code made of five upper bits and three lower bits. Every step takes one clock cycle, and a single start pulse begins the whole sequence. A word that is not a clean thermometer pattern still decodes from its count of ones, and the block raises a flag for it alongside the result.

Top module: `subrange_decoder`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `result_valid`, `ladder_sel` and `bubble_err` are 0, and `win_sel` and `result` are 0.
- R2: The window code is the number of ones k in `est_therm`, mapped to (k+1)/2 rounded down and capped at 3. So k = 0 gives 0, k = 1..2 give 1, k = 3..4 give 2 and k = 5..6 give 3; the pattern 000111 gives 2. The code appears on `win_sel` from the second cycle after start and holds until the next conversion.
- R3: A start pulse sampled in the idle state produces exactly one cycle of `result_valid`, on the sixth clock edge after that start edge. `busy` is high from the first edge through the cycle in which `result_valid` is high.
- R4: `ladder_sel` is 0 (coarse ladder) while the first flash word is captured on the third edge after start. It is 1 (fine ladder) for the two cycles after that, and it returns to 0 when the result is presented.
- R5: With window code g, c1 ones in the first flash word and c2 ones in the second, `result` equals 64*g + 8*c1 - 8 + c2, limited as in R7. Bit 0 of each thermometer word is the lowest-threshold comparator, and only the count of ones matters.
- R6: When the first flash word has no ones, the input lies in the lower overlap and the window code is reduced by one. The upper five bits become 8*(g-1)+7. For example, g = 2 with c1 = 0 gives upper bits 15.
- R7: A sum below 0 gives `result` 0, and a sum above 255 gives 255.
- R8: `bubble_err`, presented with `result`, is 1 when any of the three captured words has a 1 above a 0 (it is not of the form 0..01..1). Otherwise it is 0.
- R9: `start` has no effect while a conversion is in progress. The conversion finishes on schedule, and `busy` is 0 in the cycle after `result_valid`.
- R10: When the estimator reads either correctly or high by at most 8 codes, an input voltage code V in 0..255 is reproduced exactly on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when idle |
| est_therm | input | 6 | Coarse estimator thermometer word |
| flash_therm | input | 8 | Shared flash comparator thermometer word |
| win_sel | output | 2 | Window code to the comparator multiplexer |
| ladder_sel | output | 1 | 0 selects the coarse ladder, 1 the fine ladder |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Converted code, upper five bits then lower three |
| result_valid | output | 1 | One-cycle result strobe |
| bubble_err | output | 1 | A captured word was not a clean thermometer pattern |

## Verification
The assertions assume that `start` is a short pulse given in the idle state, or else is ignored. They also assume that the analog front end settles `flash_therm` within the same cycle that `win_sel` and `ladder_sel` change. The bench honours this by driving `flash_therm` combinationally from its own comparator model, or from preset words picked by `ladder_sel`. In the model runs, the estimator is kept within its correctable error (correct, or high by up to 8 codes), so the model runs expect exact reproduction. The preset-word runs use arbitrary words, bubbles included, to reach the overlap correction and both range limits.

// File: rtl/subr_pkg.sv
package subr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EST,
    ST_WIN,
    ST_MSB,
    ST_SWITCH,
    ST_LSB,
    ST_DONE
  } seq_state_t;

  // Coarse estimator: count of ones to window code, capped at top.
  function automatic int unsigned group_of(int unsigned ones, int unsigned top);
    int unsigned g;
    g = (ones + 1) >> 1;
    return (g > top) ? top : g;
  endfunction

  // Combine window code and both flash counts into an unlimited sum.
  function automatic int combine_code(int grp, int c1, int c2, int sub_sh, int lsb_w);
    return (grp <<< (sub_sh + lsb_w)) + ((c1 - 1) <<< lsb_w) + c2;
  endfunction

  function automatic int limit_code(int raw, int maxc);
    if (raw < 0) return 0;
    if (raw > maxc) return maxc;
    return raw;
  endfunction

endpackage

// File: rtl/therm_decode.sv
module therm_decode #(
  parameter int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] ones,
  output logic          bubble
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(word[i]);
    end
  end

  // A clean word 0..01..1 plus one is a power of two.
  assign bubble = (word & (word + W'(1))) != '0;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import subr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_EST;
      ST_EST:    nxt = ST_WIN;
      ST_WIN:    nxt = ST_MSB;
      ST_MSB:    nxt = ST_SWITCH;
      ST_SWITCH: nxt = ST_LSB;
      ST_LSB:    nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/result_assembler.sv
module result_assembler
  import subr_pkg::*;
#(
  parameter int GRP_W  = 2,
  parameter int FCW    = 4,
  parameter int SUB_SH = 3,
  parameter int LSB_W  = 3,
  parameter int OUT_W  = 8,
  localparam int RAW_W = OUT_W + 2,
  localparam int MAXC  = (1 << OUT_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_lsb,
  input  logic [GRP_W-1:0]        grp,
  input  logic [FCW-1:0]          c1,
  input  logic [FCW-1:0]          c2,
  input  logic                    bub_in,
  output logic signed [RAW_W-1:0] raw_sum,
  output logic [OUT_W-1:0]        result,
  output logic                    bubble_err
);
  int raw;
  int lim;

  always_comb begin
    raw = combine_code(int'(grp), int'(c1), int'(c2), SUB_SH, LSB_W);
    lim = limit_code(raw, MAXC);
  end

  assign raw_sum = RAW_W'(raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      bubble_err <= 1'b0;
    end else if (cap_lsb) begin
      result     <= OUT_W'(lim);
      bubble_err <= bub_in;
    end
  end
endmodule

// File: rtl/subrange_decoder.sv
module subrange_decoder
  import subr_pkg::*;
#(
  parameter int EST_W   = 6,
  parameter int FLASH_W = 8,
  parameter int GRP_W   = 2,
  parameter int LSB_W   = 3,
  localparam int SUB_SH = $clog2(FLASH_W),
  localparam int MSB_W  = GRP_W + SUB_SH,
  localparam int OUT_W  = MSB_W + LSB_W,
  localparam int ECW    = $clog2(EST_W + 1),
  localparam int FCW    = $clog2(FLASH_W + 1),
  localparam int RAW_W  = OUT_W + 2,
  localparam int MAX_GRP = (1 << GRP_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [EST_W-1:0]   est_therm,
  input  logic [FLASH_W-1:0] flash_therm,
  output logic [GRP_W-1:0]   win_sel,
  output logic               ladder_sel,
  output logic               busy,
  output logic [OUT_W-1:0]   result,
  output logic               result_valid,
  output logic               bubble_err
);
  seq_state_t state;
  logic [ECW-1:0] est_ones;
  logic           est_bub;
  logic [FCW-1:0] fl_ones;
  logic           fl_bub;
  logic           cap_est, cap_msb, cap_lsb;
  logic [GRP_W-1:0] grp_q;
  logic [FCW-1:0]   c1_q;
  logic             bub_q;
  logic signed [RAW_W-1:0] raw_sum;

  seq_ctrl u_seq (.clk(clk), .rst_n(rst_n), .start(start), .state(state));

  therm_decode #(.W(EST_W)) u_est_dec (
    .word(est_therm), .ones(est_ones), .bubble(est_bub));

  therm_decode #(.W(FLASH_W)) u_fl_dec (
    .word(flash_therm), .ones(fl_ones), .bubble(fl_bub));

  assign cap_est = (state == ST_EST);
  assign cap_msb = (state == ST_MSB);
  assign cap_lsb = (state == ST_LSB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q <= '0;
      c1_q  <= '0;
      bub_q <= 1'b0;
    end else begin
      if (cap_est) begin
        grp_q <= GRP_W'(group_of(32'(est_ones), MAX_GRP));
        bub_q <= est_bub;
      end
      if (cap_msb) begin
        c1_q  <= fl_ones;
        bub_q <= bub_q | fl_bub;
      end
    end
  end

  result_assembler #(
    .GRP_W(GRP_W), .FCW(FCW), .SUB_SH(SUB_SH), .LSB_W(LSB_W), .OUT_W(OUT_W)
  ) u_asm (
    .clk(clk), .rst_n(rst_n), .cap_lsb(cap_lsb),
    .grp(grp_q), .c1(c1_q), .c2(fl_ones), .bub_in(bub_q | fl_bub),
    .raw_sum(raw_sum), .result(result), .bubble_err(bubble_err));

  assign win_sel      = grp_q;
  assign ladder_sel   = (state == ST_SWITCH) || (state == ST_LSB);
  assign busy         = (state != ST_IDLE);
  assign result_valid = (state == ST_DONE);
endmodule

// File: rtl/subrange_decoder_chk.sv
module subrange_decoder_chk #(
  parameter int GRP_W = 2,
  parameter int OUT_W = 8,
  localparam int RAW_W = OUT_W + 2,
  localparam int MAXC  = (1 << OUT_W) - 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    ladder_sel,
  input logic                    result_valid,
  input logic [GRP_W-1:0]        win_sel,
  input logic [OUT_W-1:0]        result,
  input logic                    cap_msb,
  input logic                    cap_lsb,
  input logic signed [RAW_W-1:0] raw_sum
);
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_valid_after_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(cap_lsb));

  assert_msb_coarse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_msb |-> !ladder_sel);

  assert_lsb_fine_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lsb |-> ladder_sel);

  assert_win_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lsb || cap_msb) |-> $stable(win_sel));

  assert_clamp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lsb && (raw_sum > MAXC)) |=> (result == OUT_W'(MAXC)));

  assert_clamp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lsb && (raw_sum < 0)) |=> (result == '0));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !result_valid) |=> busy);
endmodule

bind subrange_decoder subrange_decoder_chk #(.GRP_W(GRP_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/subrange_decoder_tb.sv
module subrange_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] est_therm = '0;
  logic [7:0] flash_therm;
  logic [1:0] win_sel;
  logic       ladder_sel, busy, result_valid, bubble_err;
  logic [7:0] result;

  // bench stimulus state
  logic       preset_mode = 1'b1;
  logic [7:0] pw1 = '0, pw2 = '0;
  int         v_in = 0;
  logic [7:0] model_word;
  int         n_vec = 0, n_bad = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  subrange_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .est_therm(est_therm),
    .flash_therm(flash_therm), .win_sel(win_sel), .ladder_sel(ladder_sel),
    .busy(busy), .result(result), .result_valid(result_valid),
    .bubble_err(bubble_err));

  // Behavioural comparator bank: coarse taps 64g+8i, residue against 1..8.
  always_comb begin
    int base, c1m, rem;
    model_word = '0;
    base = 64 * int'(win_sel);
    c1m = 0;
    for (int i = 0; i < 8; i++) if (v_in >= base + 8 * i) c1m++;
    rem = v_in - (base + 8 * c1m - 8);
    for (int i = 0; i < 8; i++) begin
      if (!ladder_sel) model_word[i] = (v_in >= base + 8 * i);
      else             model_word[i] = (rem >= i + 1);
    end
  end

  assign flash_therm = preset_mode ? (ladder_sel ? pw2 : pw1) : model_word;

  function automatic int pop(logic [7:0] w);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic bit clean(logic [7:0] w);
    bit seen0 = 0;
    for (int i = 0; i < 8; i++) begin
      if (!w[i]) seen0 = 1;
      else if (seen0) return 0;
    end
    return 1;
  endfunction

  function automatic int grp_exp(int k);
    int g = k / 2 + k % 2;
    return (g > 3) ? 3 : g;
  endfunction

  function automatic logic [5:0] est_word(int k);
    return 6'((1 << k) - 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One conversion; expectations passed in; hold_start tests R9.
  task automatic convert(int g, int res, bit bub, bit hold_start, string tag);
    @(negedge clk) start = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (!hold_start || k == 6) start = 1'b0;
      if (k == 2) check(win_sel == 2'(g), {"R2 win_sel ", tag}, int'(win_sel), g);
      if (k == 3) check(!ladder_sel, {"R4 coarse ", tag}, int'(ladder_sel), 0);
      if (k == 4 || k == 5) check(ladder_sel, {"R4 fine ", tag}, int'(ladder_sel), 1);
      if (k == 5) check(busy && !result_valid, {"R3 early ", tag}, int'(result_valid), 0);
      if (k == 6) begin
        check(result_valid && busy, {"R3 valid ", tag}, int'(result_valid), 1);
        check(result == 8'(res), {"R5 result ", tag}, int'(result), res);
        check(bubble_err == bub, {"R8 bubble ", tag}, int'(bubble_err), int'(bub));
        check(!ladder_sel, {"R4 back ", tag}, int'(ladder_sel), 0);
      end
      if (k == 7) begin
        check(!result_valid, {"R3 single ", tag}, int'(result_valid), 0);
        check(!busy, {"R9 idle ", tag}, int'(busy), 0);
      end
    end
  endtask

  task automatic preset_run(logic [5:0] e, logic [7:0] w1, logic [7:0] w2, string tag);
    int g, raw, lim;
    bit bub;
    preset_mode = 1'b1;
    est_therm = e; pw1 = w1; pw2 = w2;
    g = grp_exp(pop({2'b00, e}));
    raw = g * 64 + pop(w1) * 8 - 8 + pop(w2);
    lim = raw < 0 ? 0 : (raw > 255 ? 255 : raw);
    bub = !clean({2'b00, e}) || !clean(w1) || !clean(w2);
    convert(g, lim, bub, 1'b0, tag);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(!busy && !result_valid && !ladder_sel && !bubble_err, "R1 flags", int'(busy), 0);
    check(win_sel == 0 && result == 0, "R1 data", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !result_valid && result == 0, "R1 after release", int'(result), 0);

    // directed
    preset_run(6'b000111, 8'h0F, 8'h03, "R2 pattern 000111");
    preset_run(6'b000111, 8'h00, 8'h07, "R6 lower overlap");
    check(result[7:3] == 5'd15, "R6 upper bits", int'(result[7:3]), 15);
    preset_run(6'b000000, 8'h00, 8'h0F, "R7 low clamp");
    preset_run(6'b111111, 8'hFF, 8'hFF, "R7 high clamp");
    preset_run(6'b000111, 8'h05, 8'h01, "R8 flash bubble");
    preset_run(6'b000101, 8'h01, 8'h01, "R8 est bubble");
    preset_mode = 1'b1; est_therm = 6'b000011; pw1 = 8'h07; pw2 = 8'h01;
    convert(1, 64 + 24 - 8 + 1, 1'b0, 1'b1, "R9 start held");

    // random preset words, bubbles included
    for (int n = 0; n < 60; n++) begin
      logic [5:0] e;
      e = ($urandom % 4 == 0) ? 6'($urandom) : est_word(int'($urandom % 7));
      preset_run(e, 8'($urandom), ($urandom % 2) ? 8'($urandom) : 8'((1 << ($urandom % 9)) - 1),
                 "R5 random preset");
    end

    // model-driven, estimator correct or high by up to 8 codes
    for (int n = 0; n < 120; n++) begin
      int v, g, k;
      v = int'($urandom % 256);
      g = ($urandom % 2) ? (v >> 6) : (((v + 8) >> 6) > 3 ? 3 : ((v + 8) >> 6));
      k = (g > 0 && ($urandom % 2)) ? 2 * g - 1 : 2 * g;
      preset_mode = 1'b0;
      v_in = v;
      est_therm = est_word(k);
      convert(g, v, 1'b0, 1'b0, "R10 model");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule